// File: doc/BRIEF.md
# Two-Pass Time-Difference Bit Sensor

This block decides the value of one stored bit by timing two events and comparing them. A read begins with a plateline strobe. An external start pulse then launches a 32-slice propagation chain that fills with ones from slice 0 upward, one slice per clock. A comparator stop input, which is asynchronous to the clock, freezes the chain. The chain's contents at that moment are a thermometer code whose length measures the signal delay.

That first code is latched, inverted, into per-slice registers. A discharge strobe then resets the shared node. A second start pulse times the reference delay in the same way. Each slice forms the NOR of its live second-pass bit and its stored bit. The slice outputs are OR-reduced into the decision, so the common offset cancels without any binary arithmetic. The sensed bit is presented for one cycle together with a write-back strobe. A timeout flag reports any pass that ran out of chain before its stop arrived.

The read request is a valid/ready handshake. The result side has no back-pressure: `data_valid` is a single-cycle pulse that the sink must take when it appears, and `data_out` holds its value until the next read finishes. Starts, stops and the three strobes are plain level or pulse pins.

Top module: `tds_sense`

## Requirements
- R1: `req_ready` is high only while no read is in progress, including out of reset. A cycle with `req_valid` and `req_ready` both high accepts a read and drops `req_ready` on the next cycle. `plate_strobe` is then high for exactly PLATE_CYC (3) consecutive cycles.
- R2: A `start_pulse` is accepted only in a measurement phase, meaning after the plate phase or after the discharge phase. Only the first start of each pass counts; starts while idle or while the chain is running have no effect on the result.
- R3: The chain is a thermometer code that gains one slice of ones per clock from slice 0. `stop_in` passes through a two-flop synchroniser and an edge detector. If the start is sampled at edge P and `stop_in` is first seen high at edge P+d, the frozen code holds min(d+2, 32) ones.
- R4: Only the first rising edge of `stop_in` after a start freezes its pass. A stop that was already high before the start gives no edge, so that pass runs to saturation.
- R5: When the first pass ends, its code is stored inverted in the slice registers. The registers keep that value until the next first pass ends.
- R6: When the first pass ends, whether by stop or by saturation, `disch_strobe` is high for exactly DISCH_CYC (4) cycles. The second pass cannot start until the strobe ends.
- R7: Slice i is high only when its live second-pass bit is 0 and its stored (inverted) bit is 0. `data_out` is 1 when no slice is high and 0 otherwise. So `data_out` = 1 exactly when the first count is less than or equal to the second count, ties included.
- R8: A pass with no honoured stop ends when slice 31 fills. Its count is then 32, and `timeout` reads 1 alongside the result. `timeout` clears when the next read is accepted.
- R9: `data_valid` is high for exactly one cycle per read. `wb_strobe` rises in that same cycle and stays high for WB_CYC (3) cycles. `req_ready` returns on the cycle after `wb_strobe` ends.
- R10: At most one of `plate_strobe`, `disch_strobe` and `wb_strobe` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one chain slice per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Sequencer idle, request may be accepted |
| start_pulse | input | 1 | External start of a timing pass |
| stop_in | input | 1 | Asynchronous comparator stop |
| plate_strobe | output | 1 | Plateline pulse at the start of a read |
| disch_strobe | output | 1 | Shared-node discharge between passes |
| wb_strobe | output | 1 | Write-back of the sensed value |
| data_out | output | 1 | Sensed bit |
| data_valid | output | 1 | One-cycle qualifier for data_out |
| timeout | output | 1 | A pass of this read saturated |

## Verification
`plate_strobe` rises one cycle after the accepting edge. A stop first sampled at edge P+d freezes the chain at edge P+d+2. `disch_strobe` follows one edge after that freeze. `data_valid` arrives two edges after the second pass freezes, and `wb_strobe` starts in the same cycle. The driver computes each expected bit and timeout flag from the cycle counts d1 and d2 it applies, using the min(d+2, 32) rule, and pushes them into a queue. A monitor samples on falling edges and pops one entry per `data_valid`. It also measures the length of every strobe run and confirms that `data_valid` has fallen one cycle later. As a result, no check depends on a fixed wait time.

// File: rtl/tds_pkg.sv
package tds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PLATE, ST_MEAS1, ST_DISCH, ST_MEAS2, ST_DECIDE, ST_WB
  } tds_state_e;
endpackage

// File: rtl/tds_stop_sync.sv
module tds_stop_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_in,
  output logic stop_rise
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAST-1:0], stop_in};
  end

  // rising edge seen between the last two synchronised samples
  assign stop_rise = sh[LAST-1] & ~sh[LAST];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rise |=> !stop_rise);  // R4
endmodule

// File: rtl/tds_delay_chain.sv
module tds_delay_chain #(
  parameter int SLICES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              start,
  input  logic              stop_rise,
  output logic [SLICES-1:0] code,
  output logic              fin,
  output logic              sat
);
  logic run;
  logic start_ok;

  assign start_ok = arm & start & ~run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '0;
      run  <= 1'b0;
      fin  <= 1'b0;
      sat  <= 1'b0;
    end else begin
      fin <= 1'b0;
      sat <= 1'b0;
      if (start_ok) begin
        code <= {{(SLICES-1){1'b0}}, 1'b1};
        run  <= 1'b1;
      end else if (run) begin
        if (stop_rise) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else if (code[SLICES-1]) begin
          run <= 1'b0;
          fin <= 1'b1;
          sat <= 1'b1;
        end else begin
          code <= {code[SLICES-2:0], 1'b1};
        end
      end
    end
  end

  AST_THERMO_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (code & (code + 1'b1)) == '0);  // R3
  AST_FROZEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_ok) |=> $stable(code));  // R4
  AST_SAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> (fin && code[SLICES-1]));  // R8
endmodule

// File: rtl/tds_slice_cmp.sv
module tds_slice_cmp #(
  parameter int SLICES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [SLICES-1:0] live,
  output logic              any_hi
);
  logic [SLICES-1:0] stq;
  logic [SLICES-1:0] slice_hi;

  // registers hold the complement of the first-pass code
  always_ff @(posedge clk) begin
    if (!rst_n)   stq <= '1;
    else if (cap) stq <= ~live;
  end

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    assign slice_hi[i] = ~(live[i] | stq[i]);
  end

  assign any_hi = |slice_hi;

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(stq));  // R5
endmodule

// File: rtl/tds_sequencer.sv
module tds_sequencer import tds_pkg::*; #(
  parameter int PLATE_CYC = 3,
  parameter int DISCH_CYC = 4,
  parameter int WB_CYC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic fin,
  input  logic sat,
  input  logic any_hi,
  output logic arm,
  output logic cap,
  output logic plate_strobe,
  output logic disch_strobe,
  output logic wb_strobe,
  output logic data_out,
  output logic data_valid,
  output logic timeout
);
  localparam int MAXC = (PLATE_CYC > DISCH_CYC) ?
                        ((PLATE_CYC > WB_CYC) ? PLATE_CYC : WB_CYC) :
                        ((DISCH_CYC > WB_CYC) ? DISCH_CYC : WB_CYC);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  tds_state_e    st;
  logic [CW-1:0] cnt;

  assign req_ready    = (st == ST_IDLE);
  assign arm          = ((st == ST_MEAS1) || (st == ST_MEAS2)) && !fin;
  assign cap          = (st == ST_MEAS1) && fin;
  assign plate_strobe = (st == ST_PLATE);
  assign disch_strobe = (st == ST_DISCH);
  assign wb_strobe    = (st == ST_WB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      data_out   <= 1'b0;
      data_valid <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st      <= ST_PLATE;
          cnt     <= CW'(PLATE_CYC - 1);
          timeout <= 1'b0;
        end
        ST_PLATE: begin
          if (cnt == '0) st <= ST_MEAS1;
          else           cnt <= cnt - 1'b1;
        end
        ST_MEAS1: if (fin) begin
          st  <= ST_DISCH;
          cnt <= CW'(DISCH_CYC - 1);
          if (sat) timeout <= 1'b1;
        end
        ST_DISCH: begin
          if (cnt == '0) st <= ST_MEAS2;
          else           cnt <= cnt - 1'b1;
        end
        ST_MEAS2: if (fin) begin
          st <= ST_DECIDE;
          if (sat) timeout <= 1'b1;
        end
        ST_DECIDE: begin
          st         <= ST_WB;
          cnt        <= CW'(WB_CYC - 1);
          data_out   <= ~any_hi;
          data_valid <= 1'b1;
        end
        ST_WB: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && plate_strobe));  // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);  // R9
  AST_VALID_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $rose(wb_strobe));  // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({plate_strobe, disch_strobe, wb_strobe}));  // R10
  AST_NO_ARM_IN_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
    disch_strobe |-> !arm);  // R6
endmodule

// File: rtl/tds_sense.sv
module tds_sense #(
  parameter int SLICES      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PLATE_CYC   = 3,
  parameter int DISCH_CYC   = 4,
  parameter int WB_CYC      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic start_pulse,
  input  logic stop_in,
  output logic plate_strobe,
  output logic disch_strobe,
  output logic wb_strobe,
  output logic data_out,
  output logic data_valid,
  output logic timeout
);
  logic              stop_rise;
  logic              arm;
  logic              cap;
  logic              fin;
  logic              sat;
  logic              any_hi;
  logic [SLICES-1:0] code;

  tds_stop_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .stop_in(stop_in), .stop_rise(stop_rise)
  );

  tds_delay_chain #(.SLICES(SLICES)) u_chain (
    .clk(clk), .rst_n(rst_n), .arm(arm), .start(start_pulse),
    .stop_rise(stop_rise), .code(code), .fin(fin), .sat(sat)
  );

  tds_slice_cmp #(.SLICES(SLICES)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cap(cap), .live(code), .any_hi(any_hi)
  );

  tds_sequencer #(
    .PLATE_CYC(PLATE_CYC), .DISCH_CYC(DISCH_CYC), .WB_CYC(WB_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .fin(fin), .sat(sat), .any_hi(any_hi), .arm(arm), .cap(cap),
    .plate_strobe(plate_strobe), .disch_strobe(disch_strobe),
    .wb_strobe(wb_strobe), .data_out(data_out), .data_valid(data_valid),
    .timeout(timeout)
  );
endmodule

// File: tb/sim_tds_sense.sv
module sim_tds_sense;
  localparam int PLATE_CYC = 3;
  localparam int DISCH_CYC = 4;
  localparam int WB_CYC    = 3;
  localparam int NOSTOP    = -1;

  typedef struct { bit data; bit to; int tag; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic start_pulse = 1'b0;
  logic stop_in = 1'b0;
  logic req_ready, plate_strobe, disch_strobe, wb_strobe;
  logic data_out, data_valid, timeout;

  int   n_chk  = 0;
  int   n_fail = 0;
  int   n_done = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  tds_sense u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .start_pulse(start_pulse), .stop_in(stop_in),
    .plate_strobe(plate_strobe), .disch_strobe(disch_strobe),
    .wb_strobe(wb_strobe), .data_out(data_out), .data_valid(data_valid),
    .timeout(timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cnt_of(input int d);
    if (d == NOSTOP || d + 2 > 32) return 32;
    return d + 2;
  endfunction

  // one timing pass: start sampled at edge P, stop first sampled at P+d
  task automatic run_pass(input int d, input bit restart);
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
    if (d != NOSTOP) begin
      for (int k = 1; k < d; k++) begin
        @(negedge clk);
        start_pulse = restart && (k == 2);  // R2 extra start ignored
      end
      start_pulse = 1'b0;
      stop_in = 1'b1;
    end
  endtask

  task automatic do_read(input int d1, input int d2, input bit restart,
                         input bit early_stop, input int tag);
    exp_t e;
    int c1, c2;
    c1 = early_stop ? 32 : cnt_of(d1);
    c2 = cnt_of(d2);
    e.data = (c1 <= c2);  // R7
    e.to   = (c1 == 32 && (early_stop || d1 == NOSTOP || d1 + 2 > 32)) ||
             (c2 == 32 && (d2 == NOSTOP || d2 + 2 > 32));  // R8
    e.tag  = tag;
    sb.push_back(e);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1 ready drops after accept", req_ready, 0);
    if (early_stop) stop_in = 1'b1;  // R4 edge before start is ignored
    while (plate_strobe) @(negedge clk);
    run_pass(early_stop ? NOSTOP : d1, restart);
    while (!disch_strobe) @(negedge clk);
    stop_in = 1'b0;
    while (disch_strobe) @(negedge clk);
    run_pass(d2, 1'b0);
    while (!req_ready) @(negedge clk);
    stop_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard pop plus strobe run lengths
  initial begin
    int pl = 0, dl = 0, wl = 0;
    bit pv = 0, dv = 0, wv = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!plate_strobe && pv) check(pl == PLATE_CYC, "R1 plate length", pl, PLATE_CYC);
        if (!disch_strobe && dv) check(dl == DISCH_CYC, "R6 discharge length", dl, DISCH_CYC);
        if (!wb_strobe && wv) begin
          check(wl == WB_CYC, "R9 writeback length", wl, WB_CYC);
          check(req_ready, "R9 ready after writeback", req_ready, 1);
        end
        pl = plate_strobe ? pl + 1 : 0;  pv = plate_strobe;
        dl = disch_strobe ? dl + 1 : 0;  dv = disch_strobe;
        wl = wb_strobe ? wl + 1 : 0;     wv = wb_strobe;
        if (int'(plate_strobe) + int'(disch_strobe) + int'(wb_strobe) > 1)
          check(0, "R10 strobes exclusive", 2, 1);
        if (data_valid) begin
          check(wb_strobe && wl == 1, "R9 writeback with valid", wl, 1);
          if (sb.size() == 0) check(0, "R9 unexpected valid", 1, 0);
          else begin
            exp_t e;
            e = sb.pop_front();
            check(data_out == e.data, $sformatf("R7 read %0d data", e.tag), data_out, e.data);
            check(timeout == e.to, $sformatf("R8 read %0d timeout", e.tag), timeout, e.to);
            @(negedge clk);
            check(!data_valid, "R9 valid one cycle", data_valid, 0);
            check(data_out == e.data, "R9 data held", data_out, e.data);
            wl++;
            n_done++;
          end
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    check(0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 reset ready", req_ready, 1);
    check(!data_valid && !plate_strobe && !disch_strobe && !wb_strobe,
          "R10 reset outputs quiet", data_valid, 0);
    check(!timeout, "R8 reset timeout", timeout, 0);
    start_pulse = 1'b1;  // R2 start while idle has no effect
    @(negedge clk);
    start_pulse = 1'b0;
    check(req_ready && !plate_strobe, "R2 idle start ignored", req_ready, 1);
    do_read(5, 10, 0, 0, 1);       // R3 short signal -> 1
    do_read(10, 5, 0, 0, 2);       // longer signal -> 0
    do_read(7, 7, 0, 0, 3);        // tie -> 1
    do_read(8, 7, 0, 0, 4);        // one slice longer -> 0
    do_read(1, 2, 0, 0, 5);
    do_read(29, 30, 0, 0, 6);      // 31 vs 32 with stop, no timeout
    do_read(30, 29, 0, 0, 7);
    do_read(31, 5, 0, 0, 8);       // R8 first pass saturates
    do_read(5, NOSTOP, 0, 0, 9);   // R8 second pass saturates
    do_read(NOSTOP, NOSTOP, 0, 0, 10);
    do_read(12, 6, 1, 0, 11);      // R2 restart mid-pass ignored
    do_read(0, 5, 0, 1, 12);       // R4 stop high before start
    do_read(5, 10, 0, 0, 13);      // R8 timeout cleared
    repeat (10) @(negedge clk);
    check(n_done == 13, "R9 all reads reported", n_done, 13);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule